// File: doc/BRIEF.md
# Single-Lane SPI Master Word Shifter

This block is the serial engine of a flash-oriented SPI master. It takes 32-bit words from an internal transmit FIFO and shifts each one out on a single data line. For every word sent it gathers one word from the input line and pushes that word into an internal receive FIFO. A 32-bit control word drives the engine: the clock divisor code, the idle clock level and sampling phase, four active-low target selects, manual select and manual start options, and master mode. A separate enable input gates all shifting.

The serial clock is made from the reference clock through a power-of-two divider. A word is sent lowest byte first, and each byte goes out most significant bit first. Each incoming bit lands in the same word position as the outgoing bit it was clocked against. A word starts only when transmit data is waiting and the receive FIFO has room for the answer. The divisor code is captured when a word starts, so changing it in the middle of a word has no effect on that word.

Top module: `spi_word_master`

## Requirements
- R1: With divisor code n in control bits 5:3, each serial clock half-period lasts 2^n reference cycles, and one 32-bit word keeps busy_o high for exactly 64*2^n reference cycles.
- R2: A word is sent starting with byte 0 (bits 7:0) and ending with byte 3; within each byte the most significant bit goes first.
- R3: The word gathered from miso_i is pushed to the receive FIFO, with each bit placed at the same position as the bit sent at that moment. This holds for all four combinations of control bit 1 (clock idle level) and control bit 2 (phase: 0 samples on the leading edge, 1 samples on the trailing edge).
- R4: While no word is being shifted, sclk_o equals control bit 1.
- R5: With control bit 14 clear, ss_no equals control bits 13:10 while a word is shifted and is all ones otherwise.
- R6: With control bit 14 set, ss_no equals control bits 13:10 at all times.
- R7: With control bit 15 clear, a word starts as soon as the transmit FIFO holds data. With it set, a word starts only in a cycle where start_i is high.
- R8: No word starts unless en_i and control bit 0 are both high. Dropping en_i in the middle of a word ends it in the next cycle, returns sclk_o to its idle level and pushes nothing.
- R9: The divisor code is taken when a word starts; changing it during a word leaves that word's timing unchanged.
- R10: No word starts while the receive FIFO is full; the pending word starts once an entry is popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word |
| en_i | input | 1 | Engine enable |
| start_i | input | 1 | Start pulse used when manual start is set |
| tx_push_i | input | 1 | Write tx_data_i into the transmit FIFO |
| tx_data_i | input | 32 | Word to transmit |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_pop_i | input | 1 | Remove the head of the receive FIFO |
| rx_data_o | output | 32 | Head of the receive FIFO |
| rx_empty_o | output | 1 | Receive FIFO empty |
| busy_o | output | 1 | A word is being shifted |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | NUM_SS | Active-low target selects |

## Verification
A bench target model answers on miso_i with its own word and records what it sees on mosi_o. The sweep covers every clock idle level, phase and divisor code, with words whose bytes differ, so that a swapped byte order, a reversed bit order, a wrong sampling edge or a wrong divider code each show up as a distinct miscompare or a wrong busy length. Directed sequences then hold back a word by manual start, by enable, by master mode and by a full receive FIFO. They also drop enable in the middle of a word and change the divisor during a word, telling a latched divisor apart from a live one by the busy length.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int CTRL_MSTR   = 0;
  localparam int CTRL_CPOL   = 1;
  localparam int CTRL_CPHA   = 2;
  localparam int CTRL_DIV_LO = 3;
  localparam int CTRL_DIV_W  = 3;
  localparam int CTRL_SS_LO  = 10;
  localparam int CTRL_MCS    = 14;
  localparam int CTRL_MSTART = 15;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_e;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wp_q, rp_q;
  logic          do_push, do_pop;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  // half-period is 2^code cycles; the largest needs CNT_W bits
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = CNT_W'((32'd1 << code_i) - 32'd1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_word_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpha_i,
  input  logic              cpol_i,
  input  logic              go_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_pop_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  // serial order k -> word position: low byte first, msb first inside a byte
  function automatic logic [BIT_W-1:0] lane(input logic [BIT_W-1:0] k);
    return {k[BIT_W-1:3], ~k[2:0]};
  endfunction

  eng_state_e        state_q;
  logic [CODE_W-1:0] div_q;
  logic [WORD_W-1:0] sh_q, rx_q;
  logic [BIT_W-1:0]  k_q, k_nxt;
  logic              sclk_q, mosi_q;
  logic              shifting, tick, lead, trail, sample_now;

  assign shifting   = (state_q == ST_SHIFT);
  assign lead       = tick & ~sclk_q;
  assign trail      = tick & sclk_q;
  assign sample_now = cpha_i ? trail : lead;
  assign k_nxt      = k_q + BIT_W'(1);

  spi_half_tick #(.CODE_W(CODE_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (shifting & en_i),
    .code_i (div_q),
    .tick_o (tick)
  );

  always_comb begin
    rx_word_o            = rx_q;
    rx_word_o[lane(k_q)] = miso_i;
  end

  assign rx_push_o = sample_now & (k_q == LAST_BIT);
  assign tx_pop_o  = ~shifting & go_i;
  assign sclk_o    = sclk_q ^ cpol_i;
  assign mosi_o    = mosi_q;
  assign busy_o    = shifting;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      k_q     <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            state_q <= ST_SHIFT;
            sh_q    <= tx_word_i;
            div_q   <= div_code_i;
            k_q     <= '0;
            sclk_q  <= 1'b0;
            mosi_q  <= tx_word_i[lane(BIT_W'(0))];
          end
        end
        ST_SHIFT: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
          end else if (tick) begin
            sclk_q <= ~sclk_q;
            if (sample_now)     rx_q[lane(k_q)] <= miso_i;
            if (lead && cpha_i) mosi_q <= sh_q[lane(k_q)];
            if (trail) begin
              k_q <= k_nxt;
              if (k_q == LAST_BIT) state_q <= ST_IDLE;
              else if (!cpha_i)    mosi_q <= sh_q[lane(k_nxt)];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_SS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ctrl_i,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              tx_push_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_full_o,
  input  logic              rx_pop_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_empty_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no
);
  logic [WORD_W-1:0]     tx_head, rx_word;
  logic                  tx_empty, tx_pop, rx_full, rx_push, go;
  logic [NUM_SS-1:0]     ss_field;
  logic [CTRL_DIV_W-1:0] div_code;
  logic                  unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_i[31:16], ctrl_i[9:6]};
  assign ss_field = ctrl_i[CTRL_SS_LO +: NUM_SS];
  assign div_code = ctrl_i[CTRL_DIV_LO +: CTRL_DIV_W];

  // a word needs data, room for its answer, and a start permission
  assign go = en_i & ctrl_i[CTRL_MSTR] & ~tx_empty & ~rx_full
            & (~ctrl_i[CTRL_MSTART] | start_i);

  spi_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .full_o  (tx_full_o),
    .empty_o (tx_empty)
  );

  spi_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_word),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .full_o  (rx_full),
    .empty_o (rx_empty_o)
  );

  spi_word_shifter #(.WORD_W(WORD_W), .CODE_W(CTRL_DIV_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cpha_i     (ctrl_i[CTRL_CPHA]),
    .cpol_i     (ctrl_i[CTRL_CPOL]),
    .go_i       (go),
    .div_code_i (div_code),
    .tx_word_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .rx_word_o  (rx_word),
    .rx_push_o  (rx_push),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .miso_i     (miso_i),
    .busy_o     (busy_o)
  );

  assign ss_no = (ctrl_i[CTRL_MCS] || busy_o) ? ss_field : '1;
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       ctrl_i,
  input logic              en_i,
  input logic              start_i,
  input logic              busy_o,
  input logic              sclk_o,
  input logic [NUM_SS-1:0] ss_no
);
  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o == ctrl_i[1]);

  p_auto_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[14] && !busy_o) |-> ss_no == '1);

  p_auto_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[14] && busy_o) |-> ss_no == ctrl_i[10 +: NUM_SS]);

  p_manual_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[14] |-> ss_no == ctrl_i[10 +: NUM_SS]);

  p_manual_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[15] && !start_i && !busy_o) |=> !busy_o);

  p_start_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(en_i) && $past(ctrl_i[0])));

  p_enable_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
endmodule

bind spi_word_master spi_word_master_chk #(.NUM_SS(NUM_SS)) u_chk (.*);

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = 32'h0;
  logic        en = 1'b0, start = 1'b0, tx_push = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic [31:0] tx_data = 32'h0;
  logic        tx_full, rx_empty, busy, sclk, mosi;
  logic [31:0] rx_data;
  logic [3:0]  ss_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_master #(.WORD_W(32), .FIFO_DEPTH(DEPTH), .NUM_SS(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .en_i(en), .start_i(start),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .busy_o(busy), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lane(input int k);
    return (k / 8) * 8 + 7 - (k % 8);
  endfunction

  function automatic logic [31:0] mk(input bit cpol, input bit cpha, input int code,
                                     input bit mcs, input bit mst, input logic [3:0] ss);
    logic [31:0] r = 32'h0;
    r[0] = 1'b1; r[1] = cpol; r[2] = cpha; r[5:3] = code[2:0];
    r[7:6] = 2'b11; r[13:10] = ss; r[14] = mcs; r[15] = mst; r[31] = 1'b1;
    return r;
  endfunction

  // target model
  bit          slv_on = 1'b0;
  int          slv_j = 0, slv_words = 0;
  logic [31:0] slv_reply = '0, slv_cap = '0, slv_last = '0;

  always @(sclk) begin
    if (slv_on && rst_n) begin
      if (!ctrl[2]) begin
        if (sclk !== ctrl[1]) slv_cap[lane(slv_j)] = mosi;
        else begin
          slv_j++;
          if (slv_j == 32) begin slv_last = slv_cap; slv_words++; slv_j = 0; end
          miso = slv_reply[lane(slv_j)];
        end
      end else begin
        if (sclk !== ctrl[1]) miso = slv_reply[lane(slv_j)];
        else begin
          slv_cap[lane(slv_j)] = mosi;
          slv_j++;
          if (slv_j == 32) begin slv_last = slv_cap; slv_words++; slv_j = 0; end
        end
      end
    end
  end

  task automatic slv_reset(input logic [31:0] reply);
    slv_j = 0; slv_words = 0; slv_reply = reply;
    miso = reply[lane(0)];
    slv_on = 1'b1;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); tx_push = 1'b1; tx_data = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk); d = rx_data; rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_busy();
    int w = 0;
    while (!busy && w < 3000) begin @(negedge clk); w++; end
  endtask

  // one full word; checks length, both directions, idle level and selects
  task automatic run_word(input logic [31:0] tx, input logic [31:0] reply, input int exp_cnt,
                          input int chg_at, input int chg_code);
    int c = 0;
    logic [3:0] ss_mid = 4'h0;
    logic [31:0] got;
    slv_reset(reply);
    push(tx);
    wait_busy();
    while (busy && c < 40000) begin
      c++;
      if (c == 2) ss_mid = ss_n;
      if (c == chg_at) ctrl[5:3] = chg_code[2:0];
      @(negedge clk);
    end
    chk("R1 word length", c, exp_cnt);
    chk("R4 idle clock level", {31'h0, sclk}, {31'h0, ctrl[1]});
    chk("R5 select during word", {28'h0, ss_mid}, {28'h0, ctrl[13:10]});
    if (!ctrl[14]) chk("R5 deselect after word", {28'h0, ss_n}, 32'hF);
    chk("R2 serial order seen by target", slv_last, tx);
    chk("R3 rx fifo not empty", {31'h0, rx_empty}, 32'h0);
    pop(got);
    chk("R3 received word", got, reply);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    chk("R4 reset sclk", {31'h0, sclk}, 32'h0);
    chk("R5 reset selects", {28'h0, ss_n}, 32'hF);
    chk("R8 reset busy", {31'h0, busy}, 32'h0);
    chk("R3 reset rx empty", {31'h0, rx_empty}, 32'h1);
    rst_n = 1'b1;
    en = 1'b1;

    // sweep: every mode and divisor code
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 8; n++) begin
        logic [31:0] tx, rp;
        slv_on = 1'b0;
        ctrl = mk(p[0], p[1], n, 1'b0, 1'b0, ~(4'b1 << (n % 4)));
        repeat (2) @(negedge clk);
        tx = 32'h8142_C3A5 ^ (32'h0101_0101 * (p * 8 + n));
        rp = {tx[7:0], tx[31:8]} ^ 32'h3C96_5AE1;
        run_word(tx, rp, 64 * (1 << n), -1, 0);
      end
    end

    // R6 manual select
    slv_on = 1'b0;
    ctrl = mk(1'b0, 1'b0, 0, 1'b1, 1'b0, 4'b1011);
    repeat (2) @(negedge clk);
    chk("R6 manual select while idle", {28'h0, ss_n}, 32'hB);
    run_word(32'h1234_5678, 32'h9ABC_DEF0, 64, -1, 0);
    chk("R6 manual select after word", {28'h0, ss_n}, 32'hB);

    // R7 manual start
    slv_on = 1'b0;
    ctrl = mk(1'b1, 1'b1, 0, 1'b0, 1'b1, 4'b1110);
    repeat (2) @(negedge clk);
    slv_reset(32'h0F0F_A0A0);
    push(32'hDEAD_BEEF);
    repeat (20) @(negedge clk);
    chk("R7 held without start pulse", {31'h0, busy}, 32'h0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R7 start pulse begins word", {31'h0, busy}, 32'h1);
    while (busy) @(negedge clk);
    chk("R7 word sent after start", slv_last, 32'hDEAD_BEEF);
    pop(got);
    chk("R7 word received after start", got, 32'h0F0F_A0A0);

    // R8 enable and master gating
    slv_on = 1'b0;
    ctrl = mk(1'b0, 1'b1, 0, 1'b0, 1'b0, 4'b0111);
    en = 1'b0;
    repeat (2) @(negedge clk);
    slv_reset(32'h5555_AAAA);
    push(32'h0123_4567);
    repeat (20) @(negedge clk);
    chk("R8 no word with enable low", {31'h0, busy}, 32'h0);
    chk("R8 clock idle with enable low", {31'h0, sclk}, 32'h0);
    ctrl[0] = 1'b0;
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 no word with master bit low", {31'h0, busy}, 32'h0);
    ctrl[0] = 1'b1;
    wait_busy();
    while (busy) @(negedge clk);
    chk("R8 word after gates open", slv_last, 32'h0123_4567);
    pop(got);
    chk("R8 reply after gates open", got, 32'h5555_AAAA);

    // R8 abort mid word
    slv_on = 1'b0;
    ctrl = mk(1'b1, 1'b0, 3, 1'b0, 1'b0, 4'b1101);
    repeat (2) @(negedge clk);
    slv_reset(32'hFFFF_0000);
    push(32'hCAFE_F00D);
    wait_busy();
    repeat (50) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 abort clears busy", {31'h0, busy}, 32'h0);
    chk("R8 abort restores idle level", {31'h0, sclk}, 32'h1);
    repeat (20) @(negedge clk);
    chk("R8 abort pushes nothing", {31'h0, rx_empty}, 32'h1);
    slv_on = 1'b0;
    en = 1'b1;

    // R9 divisor latched at word start
    ctrl = mk(1'b0, 1'b0, 2, 1'b0, 1'b0, 4'b1110);
    repeat (2) @(negedge clk);
    run_word(32'h7E81_18E7, 32'hA1B2_C3D4, 256, 10, 0);
    chk("R9 new code applies to next word", {29'h0, ctrl[5:3]}, 32'h0);
    run_word(32'h00FF_FF00, 32'h1357_9BDF, 64, -1, 0);

    // R10 receive FIFO full holds the next word
    slv_on = 1'b0;
    ctrl = mk(1'b1, 1'b1, 0, 1'b0, 1'b0, 4'b1011);
    repeat (2) @(negedge clk);
    slv_reset(32'h6A5B_4C3D);
    for (int i = 0; i < DEPTH; i++) push(32'h1000_0001 * (i + 1));
    begin
      int w = 0;
      while ((slv_words < DEPTH || busy) && w < 3000) begin @(negedge clk); w++; end
    end
    push(32'hB00B_1E55);
    repeat (100) @(negedge clk);
    chk("R10 no word while rx full", {31'h0, busy}, 32'h0);
    chk("R10 target saw only fifo depth words", slv_words, DEPTH);
    pop(got);
    chk("R10 first queued reply", got, 32'h6A5B_4C3D);
    begin
      int w = 0;
      while ((slv_words < DEPTH + 1 || busy) && w < 3000) begin @(negedge clk); w++; end
    end
    chk("R10 held word sent after pop", slv_last, 32'hB00B_1E55);
    for (int i = 0; i < DEPTH; i++) begin
      pop(got);
      chk("R10 queued replies", got, 32'h6A5B_4C3D);
    end
    chk("R10 rx drained", {31'h0, rx_empty}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule